// File: doc/BRIEF.md
# Shared RAM Walking-Pattern Self-Test

This block checks a single-port shared RAM of 16-bit words on request from the host. A one-cycle start strobe makes the block take over the RAM port. It then runs two passes. The first pass stores each word's own address in that word. The second pass stores the bitwise inverse of the address. In each pass every word is written first, and only then is every word read back and compared with the value expected for its address. The RAM is typically 4K or 64K words deep.

While the test runs, the host's RAM requests are ignored and a ready output is held low. When the test ends, the status outputs show that it is complete and whether it passed. They also give the address of the earliest mismatch. The test is destructive: nothing is restored afterwards. The host can therefore read the RAM directly through the same port to find the words that misbehaved. The total cost is fixed at ten clocks per word. It is split as two clocks per word in each write pass and three clocks per word in each read pass.

Top module: `ram_bist`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0, `fail_addr` is 0 and `host_ready` is 1.
- R2: A `start` pulse seen while idle makes `busy` 1 and clears `done` and `fail` on the next clock. A `start` pulse seen while busy is ignored and does not lengthen the run.
- R3: The first pass writes words 0 to N-1 in ascending order, each with its address zero-extended to 16 bits. It then reads the same words back in ascending order and compares each one with that value.
- R4: The second pass does the same with the bitwise inverse of the zero-extended address, for example 16'hFFFD for word 2.
- R5: In each pass, no read is issued before all N words of that pass are written, and no write of the second pass occurs before all reads of the first pass.
- R6: `busy` stays high for exactly 10·N clocks, where N = 2^ADDR_W. `done` becomes 1 on the same edge at which `busy` falls, and it stays 1 until the next accepted start.
- R7: Any read-back mismatch in either pass sets `fail`. `fail` stays set until the next accepted start.
- R8: `fail_addr` holds the address of the first mismatch in time, which may come from either pass. Later mismatches do not change it.
- R9: After a run, pass or fail, the RAM holds the second-pass pattern, and no earlier contents are restored.
- R10: While busy, the host request inputs have no effect on the RAM and `host_ready` is 0. While idle, the host drives the RAM port directly, and `host_rdata` shows the RAM read data one clock after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe for the self-test |
| host_en | input | 1 | Host RAM request |
| host_we | input | 1 | Host request is a write |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data returned to the host |
| host_ready | output | 1 | Host owns the RAM port (test idle) |
| ram_en | output | 1 | RAM request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, valid one clock after a read request |
| busy | output | 1 | Test running |
| done | output | 1 | Test finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |

## Verification
The bench runs the test on a 16-word RAM model. The model can force chosen data bits to read back as 1 at chosen addresses. A fault-free run checks the write and read order, the data of both passes and the exact run length. A stuck bit that sits at 1 in the first pattern but at 0 in the second is caught only by the inverted pass, and the reverse case is caught only by the first pass, so the two patterns are shown to do distinct work. A pair of faults is placed so that the higher address fails in the first pass and the lower address fails in the second. This tells "first in time" apart from "lowest address". Host traffic driven during a run, a second start pulse in the middle of a run, and idle host accesses check the port ownership rules.

// File: rtl/ram_bist_pkg.sv
package ram_bist_pkg;

  // Pass order; the low bit marks a read pass, the high bit marks the inverted pattern.
  typedef enum logic [1:0] {
    PH_WR_DIRECT = 2'd0,
    PH_RD_DIRECT = 2'd1,
    PH_WR_INVERT = 2'd2,
    PH_RD_INVERT = 2'd3
  } phase_t;

  localparam int WR_SLOTS = 2;
  localparam int RD_SLOTS = 3;
  localparam int CYCLES_PER_WORD = 2 * (WR_SLOTS + RD_SLOTS);

  function automatic logic [1:0] last_slot(input phase_t p);
    return p[0] ? 2'(RD_SLOTS - 1) : 2'(WR_SLOTS - 1);
  endfunction

  function automatic int total_cycles(input int addr_w);
    return CYCLES_PER_WORD * (1 << addr_w);
  endfunction

endpackage

// File: rtl/ram_bist_seq.sv
module ram_bist_seq
  import ram_bist_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              start_acc,
  output logic              bist_en,
  output logic              bist_we,
  output logic [ADDR_W-1:0] bist_addr,
  output logic [DATA_W-1:0] bist_wdata,
  output logic              cmp_valid,
  output logic [DATA_W-1:0] cmp_expect
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a, input logic inv);
    logic [DATA_W-1:0] w;
    w = DATA_W'(a);
    return inv ? ~w : w;
  endfunction

  phase_t            phase;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        slot;
  logic              slot_end;
  logic              pass_end;
  logic              run_end;

  assign start_acc = start && !busy;
  assign slot_end  = busy && (slot == last_slot(phase));
  assign pass_end  = slot_end && (addr == LAST_ADDR);
  assign run_end   = pass_end && (phase == PH_RD_INVERT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= PH_WR_DIRECT;
      addr  <= '0;
      slot  <= '0;
    end else if (start_acc) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      phase <= PH_WR_DIRECT;
      addr  <= '0;
      slot  <= '0;
    end else if (busy) begin
      if (!slot_end) begin
        slot <= slot + 2'd1;
      end else begin
        slot <= '0;
        addr <= addr + 1'b1;
        if (run_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (pass_end) begin
          phase <= phase_t'(phase + 2'd1);
        end
      end
    end
  end

  assign bist_en    = busy && (slot == 2'd0);
  assign bist_we    = !phase[0];
  assign bist_addr  = addr;
  assign bist_wdata = pattern(addr, phase[1]);
  assign cmp_valid  = busy && phase[0] && (slot == 2'd1);
  assign cmp_expect = pattern(addr, phase[1]);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done); // R2
  AST_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(bist_en) && !$past(bist_we)); // R5

endmodule

// File: rtl/ram_bist_cmp.sv
module ram_bist_cmp #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cmp_valid,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] cmp_expect,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  logic mismatch;
  assign mismatch = cmp_valid && (rdata != cmp_expect);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else if (mismatch) begin
      fail <= 1'b1;
      if (!fail) fail_addr <= cmp_addr;
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clear |=> fail); // R7
  AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(cmp_valid)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !clear |=> $stable(fail_addr)); // R8

endmodule

// File: rtl/ram_bist_portmux.sv
module ram_bist_portmux #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              bist_en,
  input  logic              bist_we,
  input  logic [ADDR_W-1:0] bist_addr,
  input  logic [DATA_W-1:0] bist_wdata,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);

  always_comb begin
    if (busy) begin
      ram_en    = bist_en;
      ram_we    = bist_we;
      ram_addr  = bist_addr;
      ram_wdata = bist_wdata;
    end else begin
      ram_en    = host_en;
      ram_we    = host_we;
      ram_addr  = host_addr;
      ram_wdata = host_wdata;
    end
  end

  assign host_ready = !busy;

  AST_HOST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_en && !bist_en |-> !ram_en); // R10

endmodule

// File: rtl/ram_bist.sv
module ram_bist #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ready,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);

  logic              start_acc;
  logic              bist_en;
  logic              bist_we;
  logic [ADDR_W-1:0] bist_addr;
  logic [DATA_W-1:0] bist_wdata;
  logic              cmp_valid;
  logic [DATA_W-1:0] cmp_expect;

  ram_bist_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .start_acc(start_acc),
    .bist_en(bist_en), .bist_we(bist_we), .bist_addr(bist_addr),
    .bist_wdata(bist_wdata), .cmp_valid(cmp_valid), .cmp_expect(cmp_expect)
  );

  ram_bist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start_acc),
    .cmp_valid(cmp_valid), .cmp_addr(bist_addr), .cmp_expect(cmp_expect),
    .rdata(ram_rdata), .fail(fail), .fail_addr(fail_addr)
  );

  ram_bist_portmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .bist_en(bist_en), .bist_we(bist_we), .bist_addr(bist_addr), .bist_wdata(bist_wdata),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ready(host_ready),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  assign host_rdata = ram_rdata;

endmodule

// File: tb/ram_bist_bench.sv
module ram_bist_bench;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int N  = 1 << AW;
  localparam int RUN_LEN = 10 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          host_en = 1'b0;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_ready;
  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;
  logic          busy, done, fail;
  logic [AW-1:0] fail_addr;

  always #10 clk = ~clk;

  ram_bist #(.ADDR_W(AW), .DATA_W(DW)) u_ram_bist (
    .clk(clk), .rst_n(rst_n), .start(start),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  // RAM model with stuck-at-1 bits on the read path
  logic [DW-1:0] mem [0:N-1];
  int            fa_addr = 0, fb_addr = 0;
  logic [DW-1:0] fa_mask = '0, fb_mask = '0;

  function automatic logic [DW-1:0] stuck(input int a);
    logic [DW-1:0] m;
    m = '0;
    if (a == fa_addr) m = m | fa_mask;
    if (a == fb_addr) m = m | fb_mask;
    return m;
  endfunction

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else ram_rdata <= mem[ram_addr] | stuck(int'(ram_addr));
    end
  end

  // Traffic monitor: order and data of every test access
  int wr_cnt = 0, rd_cnt = 0, wr_err = 0, rd_err = 0;
  always @(posedge clk) begin
    if (start && !busy) begin
      wr_cnt = 0; rd_cnt = 0; wr_err = 0; rd_err = 0;
    end else if (busy && ram_en) begin
      if (ram_we) begin
        logic [DW-1:0] e;
        e = DW'(wr_cnt % N);
        if (wr_cnt >= N) e = ~e;
        if (int'(ram_addr) != wr_cnt % N || ram_wdata != e) wr_err++;
        if (rd_cnt != ((wr_cnt < N) ? 0 : N)) wr_err++;
        wr_cnt++;
      end else begin
        if (int'(ram_addr) != rd_cnt % N) rd_err++;
        if (wr_cnt != ((rd_cnt < N) ? N : 2 * N)) rd_err++;
        rd_cnt++;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int  run_cycles;
  logic ready_mid;

  // poke: extra start mid-run; hammer: host write to word 2 throughout
  task automatic run_test(input bit poke, input bit hammer);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (hammer) begin
      host_en = 1'b1; host_we = 1'b1; host_addr = AW'(2); host_wdata = 16'hDEAD;
    end
    run_cycles = 0;
    ready_mid = 1'b1;
    while (busy && run_cycles < 5000) begin
      run_cycles++;
      if (run_cycles == 50) ready_mid = host_ready;
      start = poke && (run_cycles == 37);
      @(negedge clk);
    end
    start = 1'b0;
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [DW-1:0] d);
    host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    @(negedge clk);
    host_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic host_write(input int a, input logic [DW-1:0] d);
    host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic check_inverted_image(input string req);
    int bad;
    bad = 0;
    for (int a = 0; a < N; a++) if (mem[a] !== ~DW'(a)) bad++;
    chk(req, bad, 0);
  endtask

  initial begin
    for (int a = 0; a < N; a++) mem[a] = 16'h5A5A;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 fail_addr", fail_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 host_ready", host_ready, 1);

    // R10: idle host access reaches RAM, read data one clock later
    begin
      logic [DW-1:0] d;
      host_write(4, 16'h1234);
      host_read(4, d);
      chk("R10 idle host read", d, 16'h1234);
    end

    // Clean run, host hammering word 2, extra start mid-run
    run_test(1'b1, 1'b1);
    chk("R6 run length with mid-run start (R2)", run_cycles, RUN_LEN);
    chk("R6 done at end", done, 1);
    chk("R7 clean run passes", fail, 0);
    chk("R3 R4 write order and data", wr_err, 0);
    chk("R3 R5 read order", rd_err, 0);
    chk("R5 write count", wr_cnt, 2 * N);
    chk("R5 read count", rd_cnt, 2 * N);
    chk("R10 host_ready low while busy", ready_mid, 0);
    check_inverted_image("R9 image after pass");
    begin
      logic [DW-1:0] d;
      host_read(2, d);
      chk("R10 host write during run ignored", d, 16'hFFFD);
      host_read(7, d);
      chk("R4 word 7 inverted", d, 16'hFFF8);
    end

    // Fault caught only by the first pattern: word 6 bit0 stuck at 1
    fa_addr = 6; fa_mask = 16'h0001;
    run_test(1'b0, 1'b0);
    chk("R3 first-pattern fault flagged", fail, 1);
    chk("R8 fail_addr first-pattern fault", fail_addr, 6);
    chk("R6 run length with fault", run_cycles, RUN_LEN);
    check_inverted_image("R9 image after fail");

    // Fault caught only by the inverted pattern: word 3 bit0 stuck at 1
    fa_addr = 3; fa_mask = 16'h0001;
    run_test(1'b0, 1'b0);
    chk("R4 inverted-pattern fault flagged", fail, 1);
    chk("R8 fail_addr inverted fault", fail_addr, 3);

    // Two faults: word 12 fails in pass one, word 3 in pass two -> 12 first
    fb_addr = 12; fb_mask = 16'h8000;
    run_test(1'b0, 1'b0);
    chk("R8 first in time wins", fail_addr, 12);
    repeat (20) @(negedge clk);
    chk("R7 fail sticky while idle", fail, 1);
    chk("R6 done held while idle", done, 1);

    // Two first-pass faults: 5 before 9
    fa_addr = 5; fa_mask = 16'h8000;
    fb_addr = 9; fb_mask = 16'h8000;
    run_test(1'b0, 1'b0);
    chk("R8 lower of two same-pass faults", fail_addr, 5);

    // Restart clears status, then a clean run passes
    fa_mask = '0; fb_mask = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", busy, 1);
    chk("R2 fail cleared by start", fail, 0);
    chk("R2 done cleared by start", done, 0);
    while (busy) @(negedge clk);
    chk("R7 clean rerun passes", fail, 0);
    chk("R8 fail_addr cleared", fail_addr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule